// File: doc/BRIEF.md
# UART Interrupt Identification and Line Status Core

This block is the register-facing core of a 16550-compatible serial port. It holds the interrupt enables, the line control byte, the modem control byte, a scratch byte and the baud divisor. It also keeps a receive queue that works either as a single holding slot or as a deep FIFO. From the state of the queue, an overrun flag, a pending transmit-empty event and an external modem-change level, it picks one interrupt reason by fixed priority. It drives one interrupt line and returns the matching identification byte.

A host sees one access port. Each access lasts one cycle and has a 3-bit offset, a write flag and a write byte. Read data comes back, registered, in the next cycle. Some reads have side effects, and these take place at the edge of the access:
- Reading the identification register discharges a transmit-empty event when that event is the reason it reports.
- Reading line status clears the overrun flag.
- Reading the data register pops the receive queue.

Received bytes come in through a push strobe from the deserializer. Bytes written to the data register go out through a one-cycle load strobe to the serializer. Bit timing and framing belong to those neighbouring blocks.

Top module: `uart_irq_core`

## Requirements
- R1: The reason has four levels, from highest to lowest:
  - line status: the overrun flag is set and IER bit 2 is set; code 0x06
  - receive: the queue is non-empty and IER bit 0 is set; reported as code 0x0C
  - transmit empty: the event is pending and IER bit 1 is set; code 0x02
  - modem: the `modem_delta` input is high and IER bit 3 is set; code 0x00
  - none of these applies: code 0x01
  An identification read (offset 2) returns the code in bits 3:0, with bits 5:4 at zero.
- R2: When pending receive data is the winning reason, the code returned is the character-timeout code 0x0C. The plain data-available code is never returned.
- R3: When the DLAB bit is clear, a write to offset 0 sets the transmit-empty event and pulses `tx_load` for one cycle with `tx_byte` equal to the written byte. An identification read that reports 0x02 clears the event. Nothing else clears it.
- R4: While the FIFO enable bit is set, the identification read returns bits 7:6 as 11. The FIFO enable bit is bit 0 of the last write to offset 2. Otherwise bits 7:6 read 00.
- R5: Offset 1 reads back bits 3:0 of the last write and zeros above them. Offset 4 keeps bits 4:0. Offsets 3 and 7 keep all 8 bits.
- R6: A line-status read (offset 5) returns:
  - bit 0: the queue is non-empty
  - bit 1: the overrun flag
  - bits 6 and 5: always 1
  - all other bits: 0
  The overrun flag is cleared after the read, unless a new overrun happens in the same cycle.
- R7: The queue holds 1 byte while the FIFO is disabled and FIFO_DEPTH bytes while it is enabled. A push that finds the queue full is dropped and sets the overrun flag. A push in the same cycle as a popping data read is accepted.
- R8: While bit 7 of offset 3 (DLAB) is set, offsets 0 and 1 read and write the divisor low and high bytes. Such accesses neither transmit, pop the queue nor touch IER. After reset the divisor is 12 (low byte 12, high byte 0).
- R9: Reads of offset 6 return 0xFF. A data read with an empty queue returns 0xFF and changes nothing. Writes to offsets 5 and 6 change no state.
- R10: `irq` is a register. It is high in the cycle after any cycle in which the computed reason is not 0x01, and low otherwise.
- R11: A write to offset 2 empties the queue in either of two cases: it changes the FIFO enable bit, or it sets both bit 0 and bit 1. A push in that same cycle is discarded without an overrun.
- R12: Every read returns its data on `acc_rdata` with `acc_rvalid` high in the following cycle. `acc_rdata` holds its value otherwise. Data reads return queued bytes in arrival order.
- R13: After reset, all of these are 0: `irq`, `acc_rvalid`, `tx_load`, IER, LCR, MCR, scratch, the overrun flag, the transmit-empty event and the FIFO enable bit. The queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register offset |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, registered |
| acc_rvalid | output | 1 | acc_rdata carries the result of the previous cycle's read |
| rx_push | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| modem_delta | input | 1 | Modem-line change indicator (level) |
| tx_load | output | 1 | One-cycle strobe: hand tx_byte to the serializer |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
The bench tests priority by stacking sources one at a time. It turns on overrun, pending receive data, a transmit-empty event and a modem change together. It then removes the winning source one step at a time and checks that the code falls through 0x06, 0x0C, 0x02, 0x00 and 0x01 in order. A wrong order or a missed clear shows up as the wrong code.

The receive queue is driven in both capacities:
- single-slot overflow
- deep fill with one extra push
- a push that coincides with a popping read at full
- flushes caused by changing the enable bit or by the reset bit

These separate a capacity error, an ordering error and a flush-versus-push error.

DLAB and unmapped-offset accesses are mixed with data and IER traffic. This shows that the divisor aliasing neither transmits nor pops.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int DATA_W = 8;

  localparam logic [2:0] OFS_DATA    = 3'd0;
  localparam logic [2:0] OFS_IER     = 3'd1;
  localparam logic [2:0] OFS_IDENT   = 3'd2;
  localparam logic [2:0] OFS_LCR     = 3'd3;
  localparam logic [2:0] OFS_MCR     = 3'd4;
  localparam logic [2:0] OFS_LSR     = 3'd5;
  localparam logic [2:0] OFS_SPARE   = 3'd6;
  localparam logic [2:0] OFS_SCRATCH = 3'd7;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  localparam int LCR_DLAB_BIT = 7;
  localparam logic [DATA_W-1:0] DIV_LO_RESET = 8'd12;
  localparam logic [DATA_W-1:0] DIV_HI_RESET = 8'd0;
  localparam logic [DATA_W-1:0] NO_DATA      = 8'hFF;

  typedef enum logic [3:0] {
    RSN_MODEM   = 4'h0,
    RSN_NONE    = 4'h1,
    RSN_TXEMPTY = 4'h2,
    RSN_LINE    = 4'h6,
    RSN_TIMEOUT = 4'hC
  } irq_reason_e;

endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             nonempty,
  output logic             reject,
  output logic             over_one
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap;
  logic             room, accept, do_pop;

  assign cap      = single ? CNT_W'(1) : CNT_W'(DEPTH);
  assign room     = count < cap;
  assign do_pop   = pop && (count != '0) && !flush;
  assign accept   = push && !flush && (room || do_pop);
  assign reject   = push && !flush && !(room || do_pop);
  assign nonempty = count != '0;
  assign over_one = count > CNT_W'(1);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({accept, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int EN_W = 4
) (
  input  logic [EN_W-1:0] enables,
  input  logic            line_err,
  input  logic            rx_ready,
  input  logic            tx_pending,
  input  logic            modem_chg,
  output irq_reason_e     reason
);
  logic [3:0] active;

  assign active[0] = line_err   && enables[EN_LINE];
  assign active[1] = rx_ready   && enables[EN_RX];
  assign active[2] = tx_pending && enables[EN_TX];
  assign active[3] = modem_chg  && enables[EN_MODEM];

  always_comb begin
    if (active[0])      reason = RSN_LINE;
    else if (active[1]) reason = RSN_TIMEOUT;
    else if (active[2]) reason = RSN_TXEMPTY;
    else if (active[3]) reason = RSN_MODEM;
    else                reason = RSN_NONE;
  end
endmodule

// File: rtl/uart_event_flags.sv
module uart_event_flags (
  input  logic clk,
  input  logic rst,
  input  logic tx_set,
  input  logic tx_clr,
  input  logic oe_set,
  input  logic oe_clr,
  output logic tx_pending,
  output logic overrun
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pending <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (tx_set)      tx_pending <= 1'b1;
      else if (tx_clr) tx_pending <= 1'b0;
      if (oe_set)      overrun <= 1'b1;
      else if (oe_clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  output logic              acc_rvalid,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  input  logic              modem_delta,
  output logic              tx_load,
  output logic [7:0]        tx_byte,
  output logic              irq
);
  localparam int EN_W   = 4;
  localparam int MCR_W  = 5;

  logic [EN_W-1:0]   ier_q;
  logic [7:0]        lcr_q, scr_q, div_lo_q, div_hi_q;
  logic [MCR_W-1:0]  mcr_q;
  logic              fifo_en_q;

  logic              dlab, rd_acc, wr_acc;
  logic [2:0]        ofs;
  logic              div_lo_sel, div_hi_sel;
  logic              data_wr, data_rd, ier_wr, fcr_wr, lcr_wr, mcr_wr, scr_wr;
  logic              ident_rd, lsr_rd;
  logic              q_flush, q_nonempty, q_reject, q_over_one;
  logic [7:0]        q_head;
  logic              tx_pend, oe_flag;
  irq_reason_e       reason;
  logic [7:0]        lsr_val, ident_val, rd_mux;

  assign ofs    = acc_addr[2:0];
  assign dlab   = lcr_q[LCR_DLAB_BIT];
  assign rd_acc = acc_valid && !acc_write;
  assign wr_acc = acc_valid &&  acc_write;

  assign div_lo_sel = dlab && (ofs == OFS_DATA);
  assign div_hi_sel = dlab && (ofs == OFS_IER);

  assign data_wr  = wr_acc && (ofs == OFS_DATA) && !dlab;
  assign data_rd  = rd_acc && (ofs == OFS_DATA) && !dlab;
  assign ier_wr   = wr_acc && (ofs == OFS_IER)  && !dlab;
  assign fcr_wr   = wr_acc && (ofs == OFS_IDENT);
  assign lcr_wr   = wr_acc && (ofs == OFS_LCR);
  assign mcr_wr   = wr_acc && (ofs == OFS_MCR);
  assign scr_wr   = wr_acc && (ofs == OFS_SCRATCH);
  assign ident_rd = rd_acc && (ofs == OFS_IDENT);
  assign lsr_rd   = rd_acc && (ofs == OFS_LSR);

  // Mode change, or enable plus reset bit, empties the queue
  assign q_flush = fcr_wr &&
                   ((acc_wdata[0] != fifo_en_q) || (acc_wdata[0] && acc_wdata[1]));

  uart_rx_queue #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .flush    (q_flush),
    .single   (!fifo_en_q),
    .push     (rx_push),
    .push_data(rx_byte),
    .pop      (data_rd),
    .head     (q_head),
    .nonempty (q_nonempty),
    .reject   (q_reject),
    .over_one (q_over_one)
  );

  uart_irq_arbiter #(.EN_W(EN_W)) u_arb (
    .enables   (ier_q),
    .line_err  (oe_flag),
    .rx_ready  (q_nonempty),
    .tx_pending(tx_pend),
    .modem_chg (modem_delta),
    .reason    (reason)
  );

  uart_event_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .tx_set    (data_wr),
    .tx_clr    (ident_rd && (reason == RSN_TXEMPTY)),
    .oe_set    (q_reject),
    .oe_clr    (lsr_rd),
    .tx_pending(tx_pend),
    .overrun   (oe_flag)
  );

  assign lsr_val   = {1'b0, 1'b1, 1'b1, 3'b000, oe_flag, q_nonempty};
  assign ident_val = {fifo_en_q, fifo_en_q, 2'b00, reason};

  always_comb begin
    rd_mux = NO_DATA;
    if (div_lo_sel)      rd_mux = div_lo_q;
    else if (div_hi_sel) rd_mux = div_hi_q;
    else begin
      case (ofs)
        OFS_DATA:    rd_mux = q_nonempty ? q_head : NO_DATA;
        OFS_IER:     rd_mux = {{(8-EN_W){1'b0}}, ier_q};
        OFS_IDENT:   rd_mux = ident_val;
        OFS_LCR:     rd_mux = lcr_q;
        OFS_MCR:     rd_mux = {{(8-MCR_W){1'b0}}, mcr_q};
        OFS_LSR:     rd_mux = lsr_val;
        OFS_SCRATCH: rd_mux = scr_q;
        default:     rd_mux = NO_DATA;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q     <= '0;
      lcr_q     <= '0;
      mcr_q     <= '0;
      scr_q     <= '0;
      div_lo_q  <= DIV_LO_RESET;
      div_hi_q  <= DIV_HI_RESET;
      fifo_en_q <= 1'b0;
    end else begin
      if (wr_acc && div_lo_sel) div_lo_q <= acc_wdata;
      if (wr_acc && div_hi_sel) div_hi_q <= acc_wdata;
      if (ier_wr) ier_q     <= acc_wdata[EN_W-1:0];
      if (lcr_wr) lcr_q     <= acc_wdata;
      if (mcr_wr) mcr_q     <= acc_wdata[MCR_W-1:0];
      if (scr_wr) scr_q     <= acc_wdata;
      if (fcr_wr) fifo_en_q <= acc_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
      tx_load    <= 1'b0;
      tx_byte    <= '0;
      irq        <= 1'b0;
    end else begin
      acc_rvalid <= rd_acc;
      if (rd_acc)  acc_rdata <= rd_mux;
      tx_load    <= data_wr;
      if (data_wr) tx_byte <= acc_wdata;
      irq        <= (reason != RSN_NONE);
    end
  end
endmodule

module uart_irq_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_write,
  input logic [2:0] acc_addr,
  input logic       dlab,
  input logic [7:0] acc_rdata,
  input logic       acc_rvalid,
  input logic       rx_push,
  input logic [3:0] ier,
  input logic       oe_flag,
  input logic       tx_pend,
  input logic       fifo_en,
  input logic       q_over_one,
  input logic       tx_load,
  input logic       irq
);
  logic rd_acc;
  assign rd_acc = acc_valid && !acc_write;

  a_r1_ident_code: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && acc_addr == 3'd2) |=> (acc_rdata[5:4] == 2'b00) &&
      (acc_rdata[3:0] == 4'h0 || acc_rdata[3:0] == 4'h1 || acc_rdata[3:0] == 4'h2 ||
       acc_rdata[3:0] == 4'h6 || acc_rdata[3:0] == 4'hC));

  a_r3_tx_event: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_addr == 3'd0 && !dlab) |=> (tx_pend && tx_load));

  a_r5_ier_masked: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && acc_addr == 3'd1 && !dlab) |=> (acc_rdata[7:4] == 4'h0));

  a_r6_lsr_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && acc_addr == 3'd5) |=> (acc_rdata[7:5] == 3'b011 && acc_rdata[4:2] == 3'b000));

  a_r6_oe_cleared: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && acc_addr == 3'd5 && !rx_push) |=> !oe_flag);

  a_r7_single_slot: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> !q_over_one);

  a_r9_unmapped: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && acc_addr == 3'd6) |=> (acc_rdata == 8'hFF));

  a_r10_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
    (ier == 4'h0) |=> !irq);

  a_r12_rvalid: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (acc_rvalid == !$past(acc_write)));
endmodule

bind uart_irq_core uart_irq_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr[2:0]),
  .dlab      (lcr_q[7]),
  .acc_rdata (acc_rdata),
  .acc_rvalid(acc_rvalid),
  .rx_push   (rx_push),
  .ier       (ier_q),
  .oe_flag   (oe_flag),
  .tx_pend   (tx_pend),
  .fifo_en   (fifo_en_q),
  .q_over_one(q_over_one),
  .tx_load   (tx_load),
  .irq       (irq)
);

// File: tb/uart_irq_core_bench.sv
module uart_irq_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic       acc_rvalid;
  logic       rx_push = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       modem_delta = 1'b0;
  logic       tx_load;
  logic [7:0] tx_byte;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  int m_lcr, m_ier, m_mcr, m_scr, m_dll, m_dlh;
  bit m_fen, m_thre, m_oe;
  int q[$];
  int e_rdata, e_txb;
  bit e_rvalid, e_irq, e_txl;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_core #(.FIFO_DEPTH(DEPTH)) u_uart_irq_core (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_rvalid(acc_rvalid), .rx_push(rx_push), .rx_byte(rx_byte),
    .modem_delta(modem_delta), .tx_load(tx_load), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic cmp(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int m_reason();
    if (m_oe && m_ier[2]) return 'h06;
    if (q.size() > 0 && m_ier[0]) return 'h0C;
    if (m_thre && m_ier[1]) return 'h02;
    if (modem_delta && m_ier[3]) return 'h00;
    return 'h01;
  endfunction

  // One cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit v, input bit w, input int a, input int d,
                      input bit p, input int pc);
    bit dl, flush, pop, rej, lsr_rd;
    int rsn, cap;
    acc_valid = v; acc_write = w; acc_addr = a[2:0]; acc_wdata = d[7:0];
    rx_push = p; rx_byte = pc[7:0];
    dl = m_lcr[7]; rsn = m_reason(); cap = m_fen ? DEPTH : 1;
    flush = 0; pop = 0; rej = 0; lsr_rd = 0;
    e_irq = (rsn != 'h01); e_txl = 0; e_rvalid = v && !w;
    if (v && !w) begin
      case (a)
        0: if (dl) e_rdata = m_dll;
           else if (q.size() > 0) begin e_rdata = q[0]; pop = 1; end
           else e_rdata = 'hFF;
        1: e_rdata = dl ? m_dlh : m_ier;
        2: begin e_rdata = (m_fen ? 'hC0 : 0) | rsn; if (rsn == 'h02) m_thre = 0; end
        3: e_rdata = m_lcr;
        4: e_rdata = m_mcr;
        5: begin e_rdata = 'h60 | (int'(m_oe) << 1) | int'(q.size() > 0); lsr_rd = 1; end
        7: e_rdata = m_scr;
        default: e_rdata = 'hFF;
      endcase
    end
    if (v && w) begin
      case (a)
        0: if (dl) m_dll = d; else begin e_txl = 1; e_txb = d; m_thre = 1; end
        1: if (dl) m_dlh = d; else m_ier = d & 'h0F;
        2: begin
             if (d[0] != m_fen || (d[0] && d[1])) flush = 1;
             m_fen = d[0];
           end
        3: m_lcr = d;
        4: m_mcr = d & 'h1F;
        7: m_scr = d;
        default: ;
      endcase
    end
    if (flush) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (p) begin
        if (q.size() < cap) q.push_back(pc & 'hFF);
        else rej = 1;
      end
    end
    if (lsr_rd) m_oe = 0;
    if (rej) m_oe = 1;
    @(posedge clk);
    @(negedge clk);
    cmp("model irq (R10)", irq, e_irq);
    cmp("model rvalid (R12)", acc_rvalid, e_rvalid);
    cmp("model rdata (R12)", acc_rdata, e_rdata);
    cmp("model tx_load (R3)", tx_load, e_txl);
    if (e_txl) cmp("model tx_byte (R3)", tx_byte, e_txb);
  endtask

  task automatic wr(input int a, input int d); step(1, 1, a, d, 0, 0); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask
  task automatic push(input int c); step(0, 0, 0, 0, 1, c); endtask
  task automatic rd(input int a, input int exp, input string tag);
    step(1, 0, a, 0, 0, 0);
    cmp(tag, acc_rdata, exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (R12): got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    m_lcr = 0; m_ier = 0; m_mcr = 0; m_scr = 0; m_dll = 12; m_dlh = 0;
    m_fen = 0; m_thre = 0; m_oe = 0; e_rdata = 0; e_txb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    cmp("R13 irq after reset", irq, 0);
    cmp("R13 rvalid after reset", acc_rvalid, 0);
    cmp("R13 tx_load after reset", tx_load, 0);
    rd(2, 'h01, "R13 ident idle");
    rd(5, 'h60, "R13 lsr idle");
    rd(1, 'h00, "R13 ier zero");

    // divisor aliasing
    wr(3, 'h83);
    rd(0, 12, "R8 divisor low reset");
    rd(1, 0, "R8 divisor high reset");
    wr(0, 'h34);
    cmp("R8 divisor write no transmit", tx_load, 0);
    rd(0, 'h34, "R8 divisor low readback");
    wr(3, 'h03);
    rd(3, 'h03, "R5 lcr readback");
    rd(2, 'h01, "R8 no tx event from divisor write");

    // register masking, scratch, ignored writes
    wr(1, 'hFF);
    rd(1, 'h0F, "R5 ier masked");
    wr(4, 'hFF);
    rd(4, 'h1F, "R5 mcr masked");
    wr(7, 'hA5);
    rd(7, 'hA5, "R5 scratch");
    rd(6, 'hFF, "R9 unmapped read");
    wr(5, 'hFF); wr(6, 'h00);
    rd(5, 'h60, "R9 lsr write ignored");
    rd(0, 'hFF, "R9 empty data read");

    // transmit-empty event
    wr(1, 'h02);
    wr(0, 'h41);
    cmp("R3 tx byte", tx_byte, 'h41);
    idle();
    cmp("R10 irq after tx event", irq, 1);
    rd(2, 'h02, "R3 ident tx empty");
    rd(2, 'h01, "R3 event cleared by ident read");
    idle();
    cmp("R10 irq released", irq, 0);

    // single-slot overrun and priority of line status
    wr(1, 'h05);
    push('h11); push('h22);
    rd(2, 'h06, "R1 line status first");
    rd(5, 'h63, "R6 lsr with overrun");
    rd(5, 'h61, "R6 overrun cleared");
    rd(2, 'h0C, "R2 receive as timeout code");
    rd(0, 'h11, "R7 first byte kept");
    rd(2, 'h01, "R1 nothing pending");

    // deep queue
    wr(2, 'h01);
    rd(2, 'hC1, "R4 fifo bits");
    for (int i = 0; i < DEPTH; i++) push(i * 3 + 1);
    rd(5, 'h61, "R7 full no overrun");
    push('h99);
    rd(5, 'h63, "R7 deep overrun");
    step(1, 0, 0, 0, 1, 'h77);
    cmp("R7 pop with push", acc_rdata, 1);
    rd(5, 'h61, "R7 push with pop accepted");
    for (int i = 1; i < DEPTH; i++) rd(0, i * 3 + 1, "R12 arrival order");
    rd(0, 'h77, "R12 last byte");
    rd(0, 'hFF, "R9 drained");

    // flushes
    push(5); push(6); push(7);
    wr(2, 'h03);
    rd(5, 'h60, "R11 reset bit flush");
    push(8);
    step(1, 1, 2, 'h00, 1, 9);
    rd(5, 'h60, "R11 mode change flush drops push");
    rd(2, 'h01, "R4 fifo bits cleared");

    // modem and full stack
    wr(1, 'h08);
    modem_delta = 1'b1;
    rd(2, 'h00, "R1 modem code");
    cmp("R10 irq for modem", irq, 1);
    wr(1, 'h0F);
    push('h31); push('h32);
    wr(0, 'h55);
    rd(2, 'h06, "R1 stack line");
    rd(5, 'h63, "R6 stack lsr");
    rd(2, 'h0C, "R1 stack receive");
    rd(0, 'h31, "R12 stack data");
    rd(2, 'h02, "R1 stack tx");
    rd(2, 'h00, "R1 stack modem");
    modem_delta = 1'b0;
    rd(2, 'h01, "R1 stack empty");
    idle(); idle();
    cmp("R10 irq idle at end", irq, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule